// File: doc/BRIEF.md
# Padded Frame Injection Formatter

This block turns one host-side frame request into the word-write sequence that a switch injection queue expects. A request carries a byte length. The block takes fixed-length header words and payload words from the host by index. It writes them to a 32-bit queue port, framed by start and end control strobes. The minimum frame size and the valid-byte rule of the last word are handled here, so the host never has to pad a frame itself. A placeholder check word of zeros closes every frame. The real check sequence is added further down the line.

A request is taken only when the queue reports that it is ready and no other frame or backoff is in progress. A refused request raises a one-cycle reject and writes nothing. After each frame the block samples the queue's watermark flag. If the flag is set, the block refuses all requests for a fixed backoff time of 50 µs, counted in clock cycles from a clock-frequency parameter. At the end of that time, it pulses a clear for the watermark counter if the flag is still set, and then accepts frames again.

Top module: `inj_word_packer`

## Requirements
- R1: A request made while the queue-ready input is low raises `rej_o` in the same cycle and causes no control or data write; `busy_o` stays low.
- R2: In the cycle after an accepted request, a start control is issued (`ctl_en_o`=1, `ctl_sof_o`=1, `ctl_gap_o`=1) with no data write.
- R3: The HDR_WORDS header words follow the start control, one data write per cycle, in index order 0 upward, before any payload word.
- R4: The number of payload words written is the byte length divided by 4, rounded up; payload word k is the host word at index k.
- R5: When fewer than MIN_BYTES/4 (15) payload words exist, all-zero words follow them until 15 data words have been written after the header.
- R6: The end control (`ctl_en_o`=1, `ctl_eof_o`=1, `ctl_gap_o`=1) immediately follows the last data word. It carries `ctl_vld_o` = length mod 4, or 0 when the length is below 60.
- R7: The cycle after the end control carries exactly one all-zero data write.
- R8: If `wm_hit_i` is high in the zero-word cycle, `busy_o` stays high for 6250 cycles (50 µs at 125 MHz) after it, requests are refused with `rej_o`, and nothing is written; without the flag, `busy_o` is low in the next cycle.
- R9: In the last backoff cycle, `wm_clr_o` pulses once if `wm_hit_i` is still high; if the flag has dropped, no pulse is given.
- R10: A request made while a frame is in progress is refused with `rej_o` and does not alter or extend the frame in progress, and no second frame follows it.
- R11: During and right after reset, no writes occur and `busy_o`, `rej_o` and `wm_clr_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Frame request |
| req_len_i | input | LEN_W | Frame length in bytes, sampled with the request |
| q_rdy_i | input | 1 | Injection queue ready flag |
| wm_hit_i | input | 1 | Queue watermark reached flag |
| hdr_idx_o | output | HIDX_W | Index of the header word requested |
| hdr_word_i | input | 32 | Header word at `hdr_idx_o` |
| pay_idx_o | output | LEN_W | Index of the payload word requested |
| pay_word_i | input | 32 | Payload word at `pay_idx_o` |
| wr_en_o | output | 1 | Data word write strobe |
| wr_data_o | output | 32 | Data word |
| ctl_en_o | output | 1 | Control write strobe |
| ctl_sof_o | output | 1 | Control marks start of frame |
| ctl_eof_o | output | 1 | Control marks end of frame |
| ctl_gap_o | output | 2 | Inter-frame gap size in the control |
| ctl_vld_o | output | 2 | Valid bytes in last word (end control) |
| busy_o | output | 1 | Frame or backoff in progress |
| rej_o | output | 1 | Request refused this cycle |
| wm_clr_o | output | 1 | Clear pulse for the watermark counter |

## Verification
The bench sweeps every length from 0 to 70 bytes and some longer lengths, so it covers each residue mod 4 on both sides of the 60-byte boundary. A design that padded to 60 bytes instead of 15 words would miss the words for lengths 57 to 59. A design that reported length mod 4 for short frames would give a nonzero valid-byte field at lengths such as 13 or 58. Frames of 61 to 64 bytes find an off-by-one in the rounding or the pad count, which shows up as one data word too many or too few before the end control. The backoff is timed to the exact cycle with the watermark both held and dropped, which catches a timer that is one cycle off and a clear that is given without regard to the flag. Requests made mid-frame and during backoff check that a second frame never starts early.

// File: rtl/inj_fmt_pkg.sv
package inj_fmt_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SOF,
      ST_HDR,
      ST_DATA,
      ST_EOF,
      ST_ZERO,
      ST_WAIT
   } inj_state_e;

   localparam int unsigned WORD_BYTES = 4;
   localparam logic [1:0]  GAP_ONE    = 2'd1;

endpackage

// File: rtl/inj_len_calc.sv
module inj_len_calc #(
   parameter int unsigned LEN_W     = 16,
   parameter int unsigned MIN_BYTES = 60
) (
   input  logic [LEN_W-1:0] len_i,
   output logic [LEN_W-1:0] pay_words_o,
   output logic [LEN_W-1:0] last_idx_o,
   output logic [1:0]       vld_o
);
   import inj_fmt_pkg::*;

   localparam int unsigned MIN_WORDS = MIN_BYTES / WORD_BYTES;

   if (MIN_BYTES % WORD_BYTES != 0) begin : g_bad_min
      $error("MIN_BYTES must be a whole number of words");
   end
   if (MIN_WORDS < 1 || MIN_BYTES >= (1 << LEN_W)) begin : g_bad_range
      $error("MIN_BYTES out of range for LEN_W");
   end

   logic [LEN_W:0]   sum;
   logic [LEN_W-1:0] total;

   always_comb begin
      sum         = {1'b0, len_i} + (LEN_W+1)'(3);
      pay_words_o = {1'b0, sum[LEN_W:2]};
      total       = (pay_words_o > LEN_W'(MIN_WORDS)) ? pay_words_o : LEN_W'(MIN_WORDS);
      last_idx_o  = total - LEN_W'(1);
      vld_o       = (len_i < LEN_W'(MIN_BYTES)) ? 2'd0 : len_i[1:0];
   end

endmodule

// File: rtl/inj_backoff_tmr.sv
module inj_backoff_tmr #(
   parameter int unsigned CYCLES = 6250
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic run_o,
   output logic done_o
);

   if (CYCLES < 1) begin : g_bad_cyc
      $error("backoff must last at least one cycle");
   end

   logic run_q;

   if (CYCLES == 1) begin : g_single
      always_ff @(posedge clk) begin
         if (!rst_n)       run_q <= 1'b0;
         else if (start_i) run_q <= 1'b1;
         else              run_q <= 1'b0;
      end
      assign done_o = run_q;
   end else begin : g_count
      localparam int unsigned CW = $clog2(CYCLES);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            run_q <= 1'b0;
            cnt_q <= '0;
         end else if (start_i) begin
            run_q <= 1'b1;
            cnt_q <= CW'(CYCLES - 1);
         end else if (run_q) begin
            if (cnt_q == '0) run_q <= 1'b0;
            else             cnt_q <= cnt_q - CW'(1);
         end
      end
      assign done_o = run_q && (cnt_q == '0);
   end

   assign run_o = run_q;

   assert_tmr_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |-> !run_q);

endmodule

// File: rtl/inj_seq_fsm.sv
module inj_seq_fsm #(
   parameter int unsigned LEN_W     = 16,
   parameter int unsigned HDR_WORDS = 9
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_i,
   input  logic                    q_rdy_i,
   input  logic                    wm_hit_i,
   input  logic [LEN_W-1:0]        last_idx_i,
   input  logic                    tmr_done_i,
   output inj_fmt_pkg::inj_state_e state_o,
   output logic [LEN_W-1:0]        cnt_o,
   output logic                    take_o,
   output logic                    rej_o,
   output logic                    tmr_start_o,
   output logic                    wm_clr_o
);
   import inj_fmt_pkg::*;

   if (HDR_WORDS < 1 || HDR_WORDS >= (1 << LEN_W)) begin : g_bad_hdr
      $error("HDR_WORDS out of range");
   end

   inj_state_e       st_q, st_d;
   logic [LEN_W-1:0] cnt_q, cnt_d;

   assign take_o      = req_i && (st_q == ST_IDLE) && q_rdy_i;
   assign rej_o       = req_i && !take_o;
   assign tmr_start_o = (st_q == ST_ZERO) && wm_hit_i;
   assign wm_clr_o    = (st_q == ST_WAIT) && tmr_done_i && wm_hit_i;

   always_comb begin
      st_d  = st_q;
      cnt_d = cnt_q;
      unique case (st_q)
         ST_IDLE: if (take_o) st_d = ST_SOF;
         ST_SOF: begin
            st_d  = ST_HDR;
            cnt_d = '0;
         end
         ST_HDR: begin
            if (cnt_q == LEN_W'(HDR_WORDS - 1)) begin
               st_d  = ST_DATA;
               cnt_d = '0;
            end else begin
               cnt_d = cnt_q + LEN_W'(1);
            end
         end
         ST_DATA: begin
            if (cnt_q == last_idx_i) st_d = ST_EOF;
            else                     cnt_d = cnt_q + LEN_W'(1);
         end
         ST_EOF:  st_d = ST_ZERO;
         ST_ZERO: st_d = wm_hit_i ? ST_WAIT : ST_IDLE;
         ST_WAIT: if (tmr_done_i) st_d = ST_IDLE;
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         cnt_q <= '0;
      end else begin
         st_q  <= st_d;
         cnt_q <= cnt_d;
      end
   end

   assign state_o = st_q;
   assign cnt_o   = cnt_q;

   assert_wait_has_timer_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_ZERO && wm_hit_i) |=> (st_q == ST_WAIT));

endmodule

// File: rtl/inj_word_packer.sv
module inj_word_packer #(
   parameter int unsigned LEN_W      = 16,
   parameter int unsigned HDR_WORDS  = 9,
   parameter int unsigned MIN_BYTES  = 60,
   parameter int unsigned CLK_MHZ    = 125,
   parameter int unsigned BACKOFF_NS = 50000,
   localparam int unsigned HIDX_W    = (HDR_WORDS > 1) ? $clog2(HDR_WORDS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic [LEN_W-1:0]  req_len_i,
   input  logic              q_rdy_i,
   input  logic              wm_hit_i,
   output logic [HIDX_W-1:0] hdr_idx_o,
   input  logic [31:0]       hdr_word_i,
   output logic [LEN_W-1:0]  pay_idx_o,
   input  logic [31:0]       pay_word_i,
   output logic              wr_en_o,
   output logic [31:0]       wr_data_o,
   output logic              ctl_en_o,
   output logic              ctl_sof_o,
   output logic              ctl_eof_o,
   output logic [1:0]        ctl_gap_o,
   output logic [1:0]        ctl_vld_o,
   output logic              busy_o,
   output logic              rej_o,
   output logic              wm_clr_o
);
   import inj_fmt_pkg::*;

   localparam int unsigned BACKOFF_CYC = (BACKOFF_NS * CLK_MHZ + 999) / 1000;

   if (LEN_W < 8) begin : g_bad_len
      $error("LEN_W too small");
   end

   inj_state_e       st;
   logic [LEN_W-1:0] cnt, len_q, pay_words, last_idx;
   logic [1:0]       vld;
   logic             take, tmr_start, tmr_run, tmr_done;

   always_ff @(posedge clk) begin
      if (!rst_n)    len_q <= '0;
      else if (take) len_q <= req_len_i;
   end

   inj_len_calc #(.LEN_W(LEN_W), .MIN_BYTES(MIN_BYTES)) i_len_calc (
      .len_i       (len_q),
      .pay_words_o (pay_words),
      .last_idx_o  (last_idx),
      .vld_o       (vld)
   );

   inj_backoff_tmr #(.CYCLES(BACKOFF_CYC)) i_backoff_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (tmr_start),
      .run_o   (tmr_run),
      .done_o  (tmr_done)
   );

   inj_seq_fsm #(.LEN_W(LEN_W), .HDR_WORDS(HDR_WORDS)) i_seq_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_i       (req_i),
      .q_rdy_i     (q_rdy_i),
      .wm_hit_i    (wm_hit_i),
      .last_idx_i  (last_idx),
      .tmr_done_i  (tmr_done),
      .state_o     (st),
      .cnt_o       (cnt),
      .take_o      (take),
      .rej_o       (rej_o),
      .tmr_start_o (tmr_start),
      .wm_clr_o    (wm_clr_o)
   );

   assign hdr_idx_o = cnt[HIDX_W-1:0];
   assign pay_idx_o = cnt;
   assign busy_o    = (st != ST_IDLE);
   assign ctl_sof_o = (st == ST_SOF);
   assign ctl_eof_o = (st == ST_EOF);
   assign ctl_en_o  = ctl_sof_o || ctl_eof_o;
   assign ctl_gap_o = ctl_en_o ? GAP_ONE : 2'd0;
   assign ctl_vld_o = ctl_eof_o ? vld : 2'd0;
   assign wr_en_o   = (st == ST_HDR) || (st == ST_DATA) || (st == ST_ZERO);

   always_comb begin
      wr_data_o = '0;
      if (st == ST_HDR)                          wr_data_o = hdr_word_i;
      else if (st == ST_DATA && cnt < pay_words) wr_data_o = pay_word_i;
   end

   assert_notrdy_rej_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && !q_rdy_i) |-> rej_o);
   assert_rej_no_sof_R1: assert property (@(posedge clk) disable iff (!rst_n)
      rej_o |=> !ctl_sof_o);
   assert_sof_then_hdr_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_sof_o |=> (wr_en_o && hdr_idx_o == '0));
   assert_short_vld_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_eof_o && len_q < LEN_W'(MIN_BYTES)) |-> (ctl_vld_o == 2'd0));
   assert_eof_then_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_eof_o |=> (wr_en_o && wr_data_o == 32'd0));
   assert_wait_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_run |-> (busy_o && !wr_en_o && !ctl_en_o));
   assert_clr_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wm_clr_o |=> !busy_o);
   assert_busy_rej_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && busy_o) |-> rej_o);

endmodule

// File: tb/test_inj_word_packer.sv
`timescale 1ns/1ps
module test_inj_word_packer;

   localparam int LEN_W  = 16;
   localparam int HDR    = 9;
   localparam int HIDX_W = 4;
   localparam int BO_CYC = 6250; // 50 us at 125 MHz

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_i = 1'b0;
   logic [LEN_W-1:0]  req_len_i = '0;
   logic              q_rdy_i = 1'b1;
   logic              wm_hit_i = 1'b0;
   logic [HIDX_W-1:0] hdr_idx_o;
   logic [31:0]       hdr_word_i;
   logic [LEN_W-1:0]  pay_idx_o;
   logic [31:0]       pay_word_i;
   logic              wr_en_o, ctl_en_o, ctl_sof_o, ctl_eof_o;
   logic [31:0]       wr_data_o;
   logic [1:0]        ctl_gap_o, ctl_vld_o;
   logic              busy_o, rej_o, wm_clr_o;

   int checks = 0;
   int errors = 0;
   logic [7:0] tag = 8'd0;

   always #4 clk = ~clk;

   assign hdr_word_i = {8'hC0, tag, 12'h000, 4'(hdr_idx_o)};
   assign pay_word_i = {8'h5A, tag, pay_idx_o};

   inj_word_packer i_inj_word_packer (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .req_len_i(req_len_i),
      .q_rdy_i(q_rdy_i), .wm_hit_i(wm_hit_i),
      .hdr_idx_o(hdr_idx_o), .hdr_word_i(hdr_word_i),
      .pay_idx_o(pay_idx_o), .pay_word_i(pay_word_i),
      .wr_en_o(wr_en_o), .wr_data_o(wr_data_o),
      .ctl_en_o(ctl_en_o), .ctl_sof_o(ctl_sof_o), .ctl_eof_o(ctl_eof_o),
      .ctl_gap_o(ctl_gap_o), .ctl_vld_o(ctl_vld_o),
      .busy_o(busy_o), .rej_o(rej_o), .wm_clr_o(wm_clr_o)
   );

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // mode 0: no watermark, 1: watermark held, 2: watermark drops during backoff
   task automatic run_frame(input int len, input int mode, input bit poke);
      int pw, total, n, clr_cnt, clr_at;
      bit quiet;
      tag = tag + 8'd1;
      pw = (len + 3) / 4;
      total = (pw > 15) ? pw : 15;
      @(negedge clk);
      req_i = 1'b1; req_len_i = LEN_W'(len);
      #1 check(!rej_o, "R1 ready accept", rej_o, 0);
      @(negedge clk);
      req_i = 1'b0;
      check(ctl_en_o && ctl_sof_o && !ctl_eof_o && ctl_gap_o == 2'd1 && !wr_en_o,
            "R2 sof", {ctl_en_o, ctl_sof_o, ctl_gap_o, wr_en_o}, 5'b11010);
      for (int h = 0; h < HDR; h++) begin
         @(negedge clk);
         req_i = 1'b0;
         check(wr_en_o && !ctl_en_o && wr_data_o == {8'hC0, tag, 12'h000, 4'(h)},
               "R3 header", wr_data_o, {8'hC0, tag, 12'h000, 4'(h)});
         if (poke && h == 2) begin
            req_i = 1'b1;
            #1 check(rej_o, "R10 busy reject", rej_o, 1);
         end
      end
      for (int d = 0; d < total; d++) begin
         logic [31:0] e;
         @(negedge clk);
         req_i = 1'b0;
         e = (d < pw) ? {8'h5A, tag, 16'(d)} : 32'd0;
         check(wr_en_o && !ctl_en_o && wr_data_o == e,
               (d < pw) ? "R4 payload" : "R5 pad", wr_data_o, e);
      end
      @(negedge clk);
      if (mode != 0) wm_hit_i = 1'b1;
      check(ctl_en_o && ctl_eof_o && !ctl_sof_o && !wr_en_o && ctl_gap_o == 2'd1 &&
            ctl_vld_o == ((len < 60) ? 2'd0 : 2'(len % 4)),
            "R6 eof vld", {ctl_en_o, ctl_eof_o, ctl_gap_o, ctl_vld_o},
            {2'b11, 2'd1, ((len < 60) ? 2'd0 : 2'(len % 4))});
      @(negedge clk);
      check(wr_en_o && !ctl_en_o && wr_data_o == 32'd0, "R7 zero word", wr_data_o, 0);
      @(negedge clk);
      if (mode == 0) begin
         check(!busy_o, "R8 no backoff", busy_o, 0);
      end else begin
         n = 0; clr_cnt = 0; clr_at = 0; quiet = 1'b1;
         while (busy_o && n < 20000) begin
            n++;
            if (mode == 2 && n == 1) wm_hit_i = 1'b0;
            if (n == 5) req_i = 1'b1;
            #1;
            if (n == 5) check(rej_o, "R8 backoff reject", rej_o, 1);
            if (wm_clr_o) begin clr_cnt++; clr_at = n; end
            if (wr_en_o || ctl_en_o) quiet = 1'b0;
            @(negedge clk);
            req_i = 1'b0;
         end
         check(n == BO_CYC, "R8 backoff length", n, BO_CYC);
         check(quiet, "R8 silent backoff", quiet, 1);
         if (mode == 1)
            check(clr_cnt == 1 && clr_at == n, "R9 clear pulse", clr_at, n);
         else
            check(clr_cnt == 0, "R9 no clear", clr_cnt, 0);
         wm_hit_i = 1'b0;
      end
      if (poke) begin
         quiet = 1'b1;
         for (int k = 0; k < 3; k++) begin
            if (ctl_en_o || wr_en_o || busy_o) quiet = 1'b0;
            @(negedge clk);
         end
         check(quiet, "R10 no second frame", quiet, 1);
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(!wr_en_o && !ctl_en_o && !busy_o && !wm_clr_o, "R11 in reset",
            {wr_en_o, ctl_en_o, busy_o, wm_clr_o}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!wr_en_o && !ctl_en_o && !busy_o && !rej_o && !wm_clr_o, "R11 after reset",
            {wr_en_o, ctl_en_o, busy_o, rej_o, wm_clr_o}, 0);

      // R1: queue not ready
      q_rdy_i = 1'b0;
      req_i = 1'b1; req_len_i = 16'd64;
      #1 check(rej_o, "R1 not ready reject", rej_o, 1);
      @(negedge clk);
      req_i = 1'b0;
      for (int k = 0; k < 4; k++) begin
         check(!wr_en_o && !ctl_en_o && !busy_o, "R1 nothing written",
               {wr_en_o, ctl_en_o, busy_o}, 0);
         @(negedge clk);
      end
      q_rdy_i = 1'b1;

      for (int len = 0; len <= 70; len++) run_frame(len, 0, len == 33);
      run_frame(100, 0, 0);
      run_frame(101, 0, 0);
      run_frame(102, 0, 1);
      run_frame(103, 0, 0);
      run_frame(1514, 0, 0);
      run_frame(61, 1, 0);
      run_frame(58, 2, 0);
      run_frame(64, 0, 0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule